// File: doc/BRIEF.md
# 8b/10b Line Encoder with Running Disparity

This block turns one byte per clock into a 10-bit transmission code group that is DC-balanced over time. For data bytes it splits the byte into a low five-bit field and a high three-bit field. It encodes each field through its own sub-block table, and the running disparity picks between the positive and negative form of each sub-code. Running disparity here is the sign of the ones-minus-zeros balance sent so far.

The encoder can also send one of twelve fixed control symbols, chosen by a 4-bit index. A control symbol goes out in a single fixed form and leaves the running disparity unchanged. An index outside the defined set raises an error flag in place of a symbol. The output is registered, so it appears one cycle after the input strobe. The current disparity is exported beside the code group so that a downstream check or a link monitor can follow it.

Top module: `tx_linecode_8b10b`

## Requirements
- R1: After reset, `code_o` is 0, `vld_o` and `err_o` are 0, and running disparity is negative (`rd_pos_o` = 0).
- R2: A strobe on `vld_i` for a data byte or a legal control index gives `vld_o` = 1 on the next cycle. A cycle with `vld_i` low gives `vld_o` = 0 and `err_o` = 0 on the next cycle, and `code_o` and `rd_pos_o` keep their values.
- R3: `data_i[4:0]` selects a 6-bit sub-code, placed in `code_o[9:4]`. The negative form is used when disparity is negative and the positive form when it is positive (for example, value 0 gives 100111 and 011000). Disparity inverts only when that sub-code has other than three ones.
- R4: `data_i[7:5]` selects a 4-bit sub-code, placed in `code_o[3:0]`. It is chosen with the disparity as already updated by the 6-bit sub-block, and disparity inverts again when the sub-code has other than two ones. `rd_pos_o` shows the disparity after the symbol.
- R5: When `data_i[7:5]` = 7, the alternate sub-code replaces the primary one under two conditions. With negative disparity and a low field of 17, 18 or 20, it is 0111. With positive disparity and a low field of 11, 13 or 14, it is 1000. Both alternate forms invert disparity.
- R6: With `ctrl_i` = 1, indexes 0 to 7 send K28.0 to K28.7, and indexes 8, 9, 10 and 11 send K23.7, K27.7, K29.7 and K30.7. Examples: index 5 gives 0011111010 and index 8 gives 1110101000. `data_i` is ignored.
- R7: Sending a control symbol leaves `rd_pos_o` unchanged.
- R8: A control index of 12 to 15 with `vld_i` gives `err_o` = 1 and `vld_o` = 0 on the next cycle. `code_o` and `rd_pos_o` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input strobe: a symbol is requested this cycle |
| ctrl_i | input | 1 | 1 selects a control symbol, 0 a data byte |
| ctrl_idx_i | input | 4 | Control symbol index |
| data_i | input | 8 | Data byte |
| code_o | output | 10 | Registered code group |
| vld_o | output | 1 | Code group valid |
| err_o | output | 1 | Illegal control index was requested |
| rd_pos_o | output | 1 | Running disparity, 1 = positive, 0 = negative |

## Verification
The assertions check on every cycle several properties of the output:
- a data code group carries four to six ones, with two to four ones in its 6-bit part;
- the ones count of a data code group agrees with how the disparity moved;
- control symbols and idle cycles leave the disparity in place;
- an error is never flagged together with a valid symbol.

Only the bench's reference model can show that each byte maps to the exact code group required. This covers the alternate-form selection around the six special low-field values and the exact control-symbol patterns. The bench compares outputs on every clock over a full byte sweep, all sixteen control indexes and a long random mix.

// File: rtl/tx_lc_pkg.sv
package tx_lc_pkg;
  localparam int LOW_W    = 5;
  localparam int HIGH_W   = 3;
  localparam int SUB6_W   = 6;
  localparam int SUB4_W   = 4;
  localparam int SYM_W    = SUB6_W + SUB4_W;
  localparam int BYTE_W   = LOW_W + HIGH_W;
  localparam int CIDX_W   = 4;
  localparam int NUM_CTRL = 12;

  typedef struct packed {
    logic [SUB6_W-1:0] neg;
    logic              flip;
  } sub6_ent_t;

  typedef struct packed {
    logic [SUB4_W-1:0] neg;
    logic              flip;
  } sub4_ent_t;

  // negative-disparity form and unbalanced flag of the 6-bit sub-code
  function automatic sub6_ent_t sub6_lookup(input logic [LOW_W-1:0] v);
    sub6_ent_t e;
    case (v)
      5'd0:  e = '{6'b100111, 1'b1};
      5'd1:  e = '{6'b011101, 1'b1};
      5'd2:  e = '{6'b101101, 1'b1};
      5'd3:  e = '{6'b110001, 1'b0};
      5'd4:  e = '{6'b110101, 1'b1};
      5'd5:  e = '{6'b101001, 1'b0};
      5'd6:  e = '{6'b011001, 1'b0};
      5'd7:  e = '{6'b111000, 1'b0};
      5'd8:  e = '{6'b111001, 1'b1};
      5'd9:  e = '{6'b100101, 1'b0};
      5'd10: e = '{6'b010101, 1'b0};
      5'd11: e = '{6'b110100, 1'b0};
      5'd12: e = '{6'b001101, 1'b0};
      5'd13: e = '{6'b101100, 1'b0};
      5'd14: e = '{6'b011100, 1'b0};
      5'd15: e = '{6'b010111, 1'b1};
      5'd16: e = '{6'b011011, 1'b1};
      5'd17: e = '{6'b100011, 1'b0};
      5'd18: e = '{6'b010011, 1'b0};
      5'd19: e = '{6'b110010, 1'b0};
      5'd20: e = '{6'b001011, 1'b0};
      5'd21: e = '{6'b101010, 1'b0};
      5'd22: e = '{6'b011010, 1'b0};
      5'd23: e = '{6'b111010, 1'b1};
      5'd24: e = '{6'b110011, 1'b1};
      5'd25: e = '{6'b100110, 1'b0};
      5'd26: e = '{6'b010110, 1'b0};
      5'd27: e = '{6'b110110, 1'b1};
      5'd28: e = '{6'b001110, 1'b0};
      5'd29: e = '{6'b101110, 1'b1};
      5'd30: e = '{6'b011110, 1'b1};
      default: e = '{6'b101011, 1'b1};
    endcase
    return e;
  endfunction

  // value 7 is balanced yet still has a mirrored positive form
  function automatic logic [SUB6_W-1:0] sub6_form(input sub6_ent_t e,
                                                  input logic [LOW_W-1:0] v,
                                                  input logic rd_pos);
    if (rd_pos && (e.flip || v == 5'd7)) return ~e.neg;
    return e.neg;
  endfunction

  function automatic sub4_ent_t sub4_lookup(input logic [HIGH_W-1:0] v);
    sub4_ent_t e;
    case (v)
      3'd0: e = '{4'b1011, 1'b1};
      3'd1: e = '{4'b1001, 1'b0};
      3'd2: e = '{4'b0101, 1'b0};
      3'd3: e = '{4'b1100, 1'b0};
      3'd4: e = '{4'b1101, 1'b1};
      3'd5: e = '{4'b1010, 1'b0};
      3'd6: e = '{4'b0110, 1'b0};
      default: e = '{4'b1110, 1'b1};
    endcase
    return e;
  endfunction

  function automatic logic [SUB4_W-1:0] sub4_form(input sub4_ent_t e,
                                                  input logic [HIGH_W-1:0] v,
                                                  input logic rd_pos);
    if (rd_pos && (e.flip || v == 3'd3)) return ~e.neg;
    return e.neg;
  endfunction

  // alternate 4-bit form condition
  function automatic logic alt7_needed(input logic [HIGH_W-1:0] hi,
                                       input logic [LOW_W-1:0] lo,
                                       input logic rd_pos);
    logic neg_hit, pos_hit;
    neg_hit = (lo == 5'd17) || (lo == 5'd18) || (lo == 5'd20);
    pos_hit = (lo == 5'd11) || (lo == 5'd13) || (lo == 5'd14);
    return (hi == 3'd7) && (rd_pos ? pos_hit : neg_hit);
  endfunction

  function automatic logic [SYM_W-1:0] ctrl_code(input logic [CIDX_W-1:0] idx);
    logic [SYM_W-1:0] c;
    case (idx)
      4'd0:  c = 10'b0011110100;
      4'd1:  c = 10'b0011111001;
      4'd2:  c = 10'b0011110101;
      4'd3:  c = 10'b0011110011;
      4'd4:  c = 10'b0011110010;
      4'd5:  c = 10'b0011111010;
      4'd6:  c = 10'b0011110110;
      4'd7:  c = 10'b0011111000;
      4'd8:  c = 10'b1110101000;
      4'd9:  c = 10'b1101101000;
      4'd10: c = 10'b1011101000;
      4'd11: c = 10'b0111101000;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tx_lc_sub6.sv
module tx_lc_sub6
  import tx_lc_pkg::*;
(
  input  logic [LOW_W-1:0]  low_i,
  input  logic              rd_i,
  output logic [SUB6_W-1:0] code_o,
  output logic              rd_o,
  output logic              flip_o
);
  sub6_ent_t ent;

  always_comb begin
    ent    = sub6_lookup(low_i);
    code_o = sub6_form(ent, low_i, rd_i);
    flip_o = ent.flip;
    rd_o   = rd_i ^ ent.flip;
  end
endmodule

// File: rtl/tx_lc_sub4.sv
module tx_lc_sub4
  import tx_lc_pkg::*;
(
  input  logic [HIGH_W-1:0] high_i,
  input  logic [LOW_W-1:0]  low_i,
  input  logic              rd_i,
  output logic [SUB4_W-1:0] code_o,
  output logic              rd_o,
  output logic              alt_o
);
  sub4_ent_t ent;

  always_comb begin
    ent   = sub4_lookup(high_i);
    alt_o = alt7_needed(high_i, low_i, rd_i);
    if (alt_o) code_o = rd_i ? 4'b1000 : 4'b0111;
    else       code_o = sub4_form(ent, high_i, rd_i);
    // both the primary and alternate forms of value 7 are unbalanced
    rd_o = rd_i ^ ent.flip;
  end
endmodule

// File: rtl/tx_lc_ctrl.sv
module tx_lc_ctrl
  import tx_lc_pkg::*;
(
  input  logic [CIDX_W-1:0] idx_i,
  output logic [SYM_W-1:0]  code_o,
  output logic              legal_o
);
  always_comb begin
    legal_o = (32'(idx_i) < NUM_CTRL);
    code_o  = ctrl_code(idx_i);
  end
endmodule

// File: rtl/tx_linecode_8b10b.sv
module tx_linecode_8b10b
  import tx_lc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              ctrl_i,
  input  logic [CIDX_W-1:0] ctrl_idx_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [SYM_W-1:0]  code_o,
  output logic              vld_o,
  output logic              err_o,
  output logic              rd_pos_o
);
  logic [SUB6_W-1:0] c6;
  logic [SUB4_W-1:0] c4;
  logic [SYM_W-1:0]  kc;
  logic              rd_mid, rd_end, sub6_flip, a7_sel, k_legal;
  logic              rd_q;

  // named events for the checker
  logic sym_data, sym_ctrl, sym_bad;
  assign sym_data = vld_i && !ctrl_i;
  assign sym_ctrl = vld_i && ctrl_i && k_legal;
  assign sym_bad  = vld_i && ctrl_i && !k_legal;

  tx_lc_sub6 u_sub6 (
    .low_i  (data_i[LOW_W-1:0]),
    .rd_i   (rd_q),
    .code_o (c6),
    .rd_o   (rd_mid),
    .flip_o (sub6_flip)
  );

  tx_lc_sub4 u_sub4 (
    .high_i (data_i[BYTE_W-1:LOW_W]),
    .low_i  (data_i[LOW_W-1:0]),
    .rd_i   (rd_mid),
    .code_o (c4),
    .rd_o   (rd_end),
    .alt_o  (a7_sel)
  );

  tx_lc_ctrl u_ctrl (
    .idx_i   (ctrl_idx_i),
    .code_o  (kc),
    .legal_o (k_legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      vld_o <= sym_data || sym_ctrl;
      err_o <= sym_bad;
      if (sym_data) begin
        code_o <= {c6, c4};
        rd_q   <= rd_end;
      end else if (sym_ctrl) begin
        code_o <= kc;
      end
    end
  end

  assign rd_pos_o = rd_q;
endmodule

// File: rtl/tx_linecode_8b10b_chk.sv
module tx_linecode_8b10b_chk
  import tx_lc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic              ctrl_i,
  input logic [CIDX_W-1:0] ctrl_idx_i,
  input logic [BYTE_W-1:0] data_i,
  input logic [SYM_W-1:0]  code_o,
  input logic              vld_o,
  input logic              err_o,
  input logic              rd_pos_o,
  input logic              sym_data,
  input logic              a7_sel
);
  logic was_data;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) was_data <= 1'b0;
    else         was_data <= sym_data;

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> !vld_o); // R8
  AST_BAD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && ctrl_i && (32'(ctrl_idx_i) >= NUM_CTRL) |=> err_o && !vld_o && $stable(rd_pos_o) && $stable(code_o)); // R8
  AST_VLD_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !ctrl_i |=> vld_o && !err_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o && !err_o && $stable(code_o) && $stable(rd_pos_o)); // R2
  AST_CTRL_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && ctrl_i |=> $stable(rd_pos_o)); // R7
  AST_DATA_WEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    was_data |-> ($countones(code_o) >= 4) && ($countones(code_o) <= 6)); // R4
  AST_SUB6_WEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    was_data |-> ($countones(code_o[9:4]) >= 2) && ($countones(code_o[9:4]) <= 4)); // R3
  AST_RD_HEAVY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    was_data && ($countones(code_o) == 6) |-> rd_pos_o && !$past(rd_pos_o)); // R4
  AST_RD_LIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    was_data && ($countones(code_o) == 4) |-> !rd_pos_o && $past(rd_pos_o)); // R4
  AST_A7_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a7_sel |-> data_i[7:5] == 3'd7); // R5
endmodule

bind tx_linecode_8b10b tx_linecode_8b10b_chk u_chk (.*);

// File: tb/tx_linecode_8b10b_bench.sv
`timescale 1ns/1ps
module tx_linecode_8b10b_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0, ctrl = 1'b0;
  logic [3:0] idx = '0;
  logic [7:0] data = '0;
  logic [9:0] code;
  logic       vld_o, err_o, rd_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  tx_linecode_8b10b u_tx_linecode_8b10b (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .ctrl_i(ctrl), .ctrl_idx_i(idx),
    .data_i(data), .code_o(code), .vld_o(vld_o), .err_o(err_o), .rd_pos_o(rd_o));

  // reference tables: both forms written out
  logic [5:0] t6n [32], t6p [32];
  logic [3:0] t4n [8],  t4p [8];
  logic [9:0] kt  [12];

  task automatic set6(input int i, input logic [5:0] n, input logic [5:0] p);
    t6n[i] = n; t6p[i] = p;
  endtask

  initial begin
    set6(0,6'b100111,6'b011000); set6(1,6'b011101,6'b100010);
    set6(2,6'b101101,6'b010010); set6(3,6'b110001,6'b110001);
    set6(4,6'b110101,6'b001010); set6(5,6'b101001,6'b101001);
    set6(6,6'b011001,6'b011001); set6(7,6'b111000,6'b000111);
    set6(8,6'b111001,6'b000110); set6(9,6'b100101,6'b100101);
    set6(10,6'b010101,6'b010101); set6(11,6'b110100,6'b110100);
    set6(12,6'b001101,6'b001101); set6(13,6'b101100,6'b101100);
    set6(14,6'b011100,6'b011100); set6(15,6'b010111,6'b101000);
    set6(16,6'b011011,6'b100100); set6(17,6'b100011,6'b100011);
    set6(18,6'b010011,6'b010011); set6(19,6'b110010,6'b110010);
    set6(20,6'b001011,6'b001011); set6(21,6'b101010,6'b101010);
    set6(22,6'b011010,6'b011010); set6(23,6'b111010,6'b000101);
    set6(24,6'b110011,6'b001100); set6(25,6'b100110,6'b100110);
    set6(26,6'b010110,6'b010110); set6(27,6'b110110,6'b001001);
    set6(28,6'b001110,6'b001110); set6(29,6'b101110,6'b010001);
    set6(30,6'b011110,6'b100001); set6(31,6'b101011,6'b010100);
    t4n[0]=4'b1011; t4p[0]=4'b0100; t4n[1]=4'b1001; t4p[1]=4'b1001;
    t4n[2]=4'b0101; t4p[2]=4'b0101; t4n[3]=4'b1100; t4p[3]=4'b0011;
    t4n[4]=4'b1101; t4p[4]=4'b0010; t4n[5]=4'b1010; t4p[5]=4'b1010;
    t4n[6]=4'b0110; t4p[6]=4'b0110; t4n[7]=4'b1110; t4p[7]=4'b0001;
    kt[0]=10'b0011110100; kt[1]=10'b0011111001; kt[2]=10'b0011110101;
    kt[3]=10'b0011110011; kt[4]=10'b0011110010; kt[5]=10'b0011111010;
    kt[6]=10'b0011110110; kt[7]=10'b0011111000; kt[8]=10'b1110101000;
    kt[9]=10'b1101101000; kt[10]=10'b1011101000; kt[11]=10'b0111101000;
  end

  // behavioural reference model, disparity as -1/+1 from weight of each part
  logic [9:0] m_code;
  logic       m_vld, m_err;
  int         m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = '0; m_vld = 0; m_err = 0; m_rd = -1;
    end else begin
      m_vld = 0; m_err = 0;
      if (vld && !ctrl) begin
        int lo, hi, w;
        logic [5:0] s6;
        logic [3:0] s4;
        lo = int'(data[4:0]); hi = int'(data[7:5]);
        s6 = (m_rd < 0) ? t6n[lo] : t6p[lo];
        w = $countones(s6);
        if (w == 4) m_rd = 1; else if (w == 2) m_rd = -1;
        if (hi == 7 && ((m_rd < 0 && (lo == 17 || lo == 18 || lo == 20)) ||
                        (m_rd > 0 && (lo == 11 || lo == 13 || lo == 14))))
          s4 = (m_rd < 0) ? 4'b0111 : 4'b1000;
        else
          s4 = (m_rd < 0) ? t4n[hi] : t4p[hi];
        w = $countones(s4);
        if (w == 3) m_rd = 1; else if (w == 1) m_rd = -1;
        m_code = {s6, s4}; m_vld = 1;
      end else if (vld && ctrl) begin
        if (idx < 12) begin m_code = kt[idx]; m_vld = 1; end
        else m_err = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", r, what, act, exp);
    end
  endtask

  task automatic compare();
    logic erd;
    erd = (m_rd > 0);
    chk(code === m_code, req, "code", code, m_code);
    chk(vld_o === m_vld, req, "vld", 10'(vld_o), 10'(m_vld));
    chk(err_o === m_err, req, "err", 10'(err_o), 10'(m_err));
    chk(rd_o === erd, req, "rd", 10'(rd_o), 10'(erd));
  endtask

  // drive after a falling edge, check at the next falling edge
  task automatic tick(input logic v, input logic c, input logic [3:0] k, input logic [7:0] d);
    vld = v; ctrl = c; idx = k; data = d;
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; vld = 0; ctrl = 0;
    repeat (2) @(negedge clk);
    req = "R1";
    compare();
    chk(code === 10'd0 && !vld_o && !err_o && !rd_o, "R1", "reset state",
        {code[9:4], vld_o, err_o, rd_o, 1'b0}, 10'd0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    req = "R3";
    tick(1, 0, 0, 8'h00);
    chk(code === 10'b1001110100, "R3", "D0.0 from negative", code, 10'b1001110100);
    chk(rd_o === 1'b0, "R4", "rd after D0.0", 10'(rd_o), 10'd0);

    do_reset();
    req = "R5";
    tick(1, 0, 0, 8'hF1);
    chk(code === 10'b1000110111, "R5", "D17.7 alternate negative", code, 10'b1000110111);
    chk(rd_o === 1'b1, "R5", "rd after D17.7", 10'(rd_o), 10'd1);
    tick(1, 0, 0, 8'hEB);
    chk(code === 10'b1101001000, "R5", "D11.7 alternate positive", code, 10'b1101001000);

    req = "R6";
    tick(1, 1, 4'd5, 8'h55);
    chk(code === 10'b0011111010, "R6", "K28.5 pattern", code, 10'b0011111010);
    chk(rd_o === 1'b0, "R7", "rd kept over control", 10'(rd_o), 10'd0);
    tick(1, 1, 4'd8, 8'h00);
    chk(code === 10'b1110101000, "R6", "K23.7 pattern", code, 10'b1110101000);

    req = "R8";
    tick(1, 1, 4'd13, 8'h00);
    chk(err_o === 1'b1 && vld_o === 1'b0, "R8", "illegal index flagged",
        {8'd0, err_o, vld_o}, 10'b10);
    chk(code === 10'b1110101000, "R8", "code held on error", code, 10'b1110101000);

    req = "R2";
    tick(0, 0, 0, 8'hFF);
    tick(0, 1, 4'd3, 8'h12);

    req = "R3,R4,R5";
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 256; b++) tick(1, 0, 0, 8'(b));

    req = "R6,R7,R8";
    for (int k = 0; k < 16; k++) tick(1, 1, 4'(k), 8'(k * 37));

    req = "R2,R4,R7";
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      tick(sel != 0, sel >= 8, 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule